// File: doc/BRIEF.md
# Concurrent Write Conflict Resolver

This block guards a shared memory location in a synchronous multiprocessor where every processing element may try to write in the same clock cycle. It samples one write request per element (a valid bit, a target address and a data word), settles the conflict under a policy chosen on a select input, and registers a single outcome: at most one committed write, plus a per-element indication of who succeeded and who was turned away. Reads never pass through it, since simultaneous reads of one location need no arbitration.

Conflicts are settled within an address group. The lowest-numbered active requester leads; every active requester naming the same address joins its group, and requesters that named some other address are refused this cycle. Four policies are supported: the group writes only when all its values agree; the group yields to one deterministic winner; the group yields to the highest-ranked element; or the values of the group are added and the total is written, with an overflow indication when the total does not fit.

The result is registered: requests sampled at one clock edge produce the commit strobe, address, data, grant, fail and overflow outputs together after that edge, and the outputs hold them for exactly one cycle.

Top module: `rcw_write_resolver`

## Requirements
- R1: While reset is asserted (rst_n low) and until the first clock edge after it is released, commit_en, grant, fail and sum_ovf are all zero.
- R2: Requests sampled at a rising clock edge produce their outcome on the outputs right after that edge, all fields together; a cycle with no valid request produces commit_en = 0 with grant, fail and sum_ovf all zero.
- R3: The leader is the valid requester with the lowest index; its group is every valid requester whose address equals the leader's. A commit always targets the leader's address, and a valid requester outside the group is flagged in fail and contributes nothing.
- R4: With policy_sel = 0 (common) and every group member carrying the same data, that data is committed and every group member is granted.
- R5: With policy_sel = 0 and any two group members carrying different data, nothing is committed, no element is granted and every valid requester is flagged in fail.
- R6: With policy_sel = 1 (arbitrary), exactly one element, the leader, is granted; its data is committed and every other valid requester is flagged in fail.
- R7: With policy_sel = 2 (priority), index 0 is the highest rank: the leader is granted and its data committed, every other valid requester fails.
- R8: With policy_sel = 3 (sum), the sum of all group members' data modulo 2^DATA_W is committed and every group member is granted.
- R9: sum_ovf is 1 exactly when policy_sel = 3 and the true sum of the group's data is 2^DATA_W or larger; it is 0 under every other policy.
- R10: No element is flagged in both grant and fail, and every element that requested gets exactly one of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_PE | Write request per element |
| req_addr | input | NUM_PE*ADDR_W | Target address per element, element i in bits [i*ADDR_W +: ADDR_W] |
| req_data | input | NUM_PE*DATA_W | Write data per element, element i in bits [i*DATA_W +: DATA_W] |
| policy_sel | input | 2 | 0 common, 1 arbitrary, 2 priority, 3 sum |
| commit_en | output | 1 | One-cycle strobe: a write is committed |
| commit_addr | output | ADDR_W | Address of the committed write |
| commit_data | output | DATA_W | Value of the committed write |
| grant | output | NUM_PE | Per element: its write succeeded |
| fail | output | NUM_PE | Per element: its write was refused |
| sum_ovf | output | 1 | Sum policy total exceeded the data width |

## Verification
On every cycle the assertions hold the per-element bookkeeping: grant and fail never overlap, exactly the elements that requested are answered, a commit always carries at least one grant, a refused common write grants nobody, the arbitrary policy names a single winner and overflow appears only under the sum policy. What value is written, to which address, and which group members are granted under each policy can only be shown by the bench's sweeps, which compare every combination of request mask, address split, data pattern and policy against arithmetic computed independently.

// File: rtl/rcw_pkg.sv
`timescale 1ns/1ps
package rcw_pkg;

    typedef enum logic [1:0] {
        POL_COMMON = 2'd0,
        POL_ANY    = 2'd1,
        POL_RANK   = 2'd2,
        POL_SUM    = 2'd3
    } policy_e;

endpackage

// File: rtl/rcw_lead_pick.sv
`timescale 1ns/1ps
// Finds the lowest-index active requester and the set of requesters
// that target the same address.
module rcw_lead_pick #(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 4,
    localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic [NUM_PE-1:0]        valid_i,
    input  logic [NUM_PE*ADDR_W-1:0] addr_i,
    output logic                     found_o,
    output logic [IDX_W-1:0]         lead_idx_o,
    output logic [ADDR_W-1:0]        lead_addr_o,
    output logic [NUM_PE-1:0]        group_o
);

    always_comb begin
        found_o    = 1'b0;
        lead_idx_o = '0;
        for (int i = NUM_PE - 1; i >= 0; i--) begin
            if (valid_i[i]) begin
                found_o    = 1'b1;
                lead_idx_o = IDX_W'(i);
            end
        end
    end

    assign lead_addr_o = addr_i[lead_idx_o*ADDR_W +: ADDR_W];

    generate
        for (genvar g = 0; g < NUM_PE; g++) begin : g_match
            assign group_o[g] = valid_i[g] &&
                                (addr_i[g*ADDR_W +: ADDR_W] == lead_addr_o);
        end
    endgenerate

endmodule

// File: rtl/rcw_value_fold.sv
`timescale 1ns/1ps
// Compares and adds the data words of the selected group.
module rcw_value_fold #(
    parameter int NUM_PE = 4,
    parameter int DATA_W = 8,
    localparam int SUM_W = DATA_W + ((NUM_PE > 1) ? $clog2(NUM_PE) : 1)
) (
    input  logic [NUM_PE-1:0]        member_i,
    input  logic [NUM_PE*DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0]        ref_i,
    output logic                     all_same_o,
    output logic [DATA_W-1:0]        sum_o,
    output logic                     carry_o
);

    logic [SUM_W-1:0]  acc;
    logic [NUM_PE-1:0] differs;

    generate
        for (genvar g = 0; g < NUM_PE; g++) begin : g_cmp
            assign differs[g] = member_i[g] &&
                                (data_i[g*DATA_W +: DATA_W] != ref_i);
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_PE; i++) begin
            if (member_i[i]) begin
                acc = acc + SUM_W'(data_i[i*DATA_W +: DATA_W]);
            end
        end
    end

    assign all_same_o = (differs == '0);
    assign sum_o      = acc[DATA_W-1:0];
    assign carry_o    = |acc[SUM_W-1:DATA_W];

endmodule

// File: rtl/rcw_write_resolver.sv
`timescale 1ns/1ps
module rcw_write_resolver
    import rcw_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PE-1:0]        req_valid,
    input  logic [NUM_PE*ADDR_W-1:0] req_addr,
    input  logic [NUM_PE*DATA_W-1:0] req_data,
    input  logic [1:0]               policy_sel,
    output logic                     commit_en,
    output logic [ADDR_W-1:0]        commit_addr,
    output logic [DATA_W-1:0]        commit_data,
    output logic [NUM_PE-1:0]        grant,
    output logic [NUM_PE-1:0]        fail,
    output logic                     sum_ovf
);

    localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [NUM_PE-1:0] grant;
        logic [NUM_PE-1:0] fail;
        logic              ovf;
    } outcome_t;

    outcome_t          out_d, out_q;
    logic              armed_d, armed_q;

    logic              found;
    logic [IDX_W-1:0]  lead_idx;
    logic [ADDR_W-1:0] lead_addr;
    logic [NUM_PE-1:0] group;
    logic [DATA_W-1:0] lead_data;
    logic              all_same;
    logic [DATA_W-1:0] sum_val;
    logic              sum_carry;
    policy_e           pol;

    rcw_lead_pick #(
        .NUM_PE (NUM_PE),
        .ADDR_W (ADDR_W)
    ) i_pick (
        .valid_i     (req_valid),
        .addr_i      (req_addr),
        .found_o     (found),
        .lead_idx_o  (lead_idx),
        .lead_addr_o (lead_addr),
        .group_o     (group)
    );

    assign lead_data = req_data[lead_idx*DATA_W +: DATA_W];

    rcw_value_fold #(
        .NUM_PE (NUM_PE),
        .DATA_W (DATA_W)
    ) i_fold (
        .member_i   (group),
        .data_i     (req_data),
        .ref_i      (lead_data),
        .all_same_o (all_same),
        .sum_o      (sum_val),
        .carry_o    (sum_carry)
    );

    assign pol = policy_e'(policy_sel);

    always_comb begin
        out_d   = '0;
        armed_d = 1'b1;
        if (found) begin
            out_d.addr = lead_addr;
            unique case (pol)
                POL_COMMON: begin
                    if (all_same) begin
                        out_d.en    = 1'b1;
                        out_d.data  = lead_data;
                        out_d.grant = group;
                    end
                end
                POL_ANY, POL_RANK: begin
                    out_d.en    = 1'b1;
                    out_d.data  = lead_data;
                    out_d.grant = NUM_PE'(1) << lead_idx;
                end
                POL_SUM: begin
                    out_d.en    = 1'b1;
                    out_d.data  = sum_val;
                    out_d.grant = group;
                    out_d.ovf   = sum_carry;
                end
                default: out_d = '0;
            endcase
            out_d.fail = req_valid & ~out_d.grant;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            out_q   <= out_d;
            armed_q <= armed_d;
        end
    end

    assign commit_en   = out_q.en;
    assign commit_addr = out_q.addr;
    assign commit_data = out_q.data;
    assign grant       = out_q.grant;
    assign fail        = out_q.fail;
    assign sum_ovf     = out_q.ovf;

    // R10: an element is never both granted and refused
    a_r10_grant_fail_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & fail) == '0);

    // R10: exactly the elements that requested one cycle earlier are answered
    a_r10_every_request_answered: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((grant | fail) == $past(req_valid)));

    // R2: a commit is always backed by at least one granted element
    a_r2_commit_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (grant != '0));

    // R5: without a commit nobody is granted
    a_r5_no_commit_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |-> (grant == '0));

    // R6: the arbitrary policy yields one winner whenever anyone asked
    a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(policy_sel) == 2'd1 && $past(req_valid) != '0)
            |-> (commit_en && $countones(grant) == 1));

    // R9: overflow is only reported for a sum commit
    a_r9_ovf_only_sum: assert property (@(posedge clk) disable iff (!rst_n)
        sum_ovf |-> (armed_q && commit_en && $past(policy_sel) == 2'd3));

endmodule

// File: tb/test_rcw_write_resolver.sv
`timescale 1ns/1ps
module test_rcw_write_resolver;

    localparam int P = 4;
    localparam int A = 4;
    localparam int D = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [P-1:0]   req_valid = '0;
    logic [P*A-1:0] req_addr = '0;
    logic [P*D-1:0] req_data = '0;
    logic [1:0]     policy_sel = '0;
    logic           commit_en;
    logic [A-1:0]   commit_addr;
    logic [D-1:0]   commit_data;
    logic [P-1:0]   grant;
    logic [P-1:0]   fail;
    logic           sum_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rcw_write_resolver #(.NUM_PE(P), .ADDR_W(A), .DATA_W(D)) i_rcw_write_resolver (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .policy_sel  (policy_sel),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .grant       (grant),
        .fail        (fail),
        .sum_ovf     (sum_ovf)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pat_data(input int k, input int i);
        case (k)
            0: return 8'h5A;
            1: return 8'h10 * (i + 1) + i;
            2: return 8'hF0;
            default: return (i == 2) ? 8'h33 : 8'hC4;
        endcase
    endfunction

    function automatic int pat_addr(input int a, input int i);
        return a[i] ? 4'h3 : 4'h9;
    endfunction

    task automatic run_vec(input int pol, input int v, input int a, input int k);
        int lead = -1;
        int grp = 0, same = 1, sum = 0;
        int e_en = 0, e_data = 0, e_grant = 0, e_fail = 0, e_ovf = 0;
        string tag;
        for (int i = 0; i < P; i++) begin
            req_addr[i*A +: A] = A'(pat_addr(a, i));
            req_data[i*D +: D] = D'(pat_data(k, i));
            if (v[i] && lead < 0) lead = i;
        end
        req_valid  = P'(v);
        policy_sel = 2'(pol);
        if (lead >= 0) begin
            for (int i = 0; i < P; i++) begin
                if (v[i] && pat_addr(a, i) == pat_addr(a, lead)) begin
                    grp |= (1 << i);
                    sum += pat_data(k, i);
                    if (pat_data(k, i) != pat_data(k, lead)) same = 0;
                end
            end
            case (pol)
                0: begin
                    tag = same ? "R4" : "R5";
                    if (same) begin e_en = 1; e_data = pat_data(k, lead); e_grant = grp; end
                end
                1, 2: begin
                    tag = (pol == 1) ? "R6" : "R7";
                    e_en = 1; e_data = pat_data(k, lead); e_grant = 1 << lead;
                end
                default: begin
                    tag = "R8";
                    e_en = 1; e_data = sum % 256; e_grant = grp; e_ovf = (sum >= 256) ? 1 : 0;
                end
            endcase
            e_fail = v & ~e_grant;
        end else begin
            tag = "R2";
        end
        @(negedge clk);
        chk(tag, "commit_en", int'(commit_en), e_en);
        if (e_en != 0) begin
            chk(tag, "commit_data", int'(commit_data), e_data);
            chk("R3", "commit_addr", int'(commit_addr), pat_addr(a, lead));
        end
        chk(tag, "grant", int'(grant), e_grant);
        chk("R3", "fail", int'(fail), e_fail);
        chk("R9", "sum_ovf", int'(sum_ovf), e_ovf);
        chk("R10", "grant|fail", int'(grant | fail), v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", "commit_en", int'(commit_en), 0);
        chk("R1", "grant", int'(grant), 0);
        chk("R1", "fail", int'(fail), 0);
        chk("R1", "sum_ovf", int'(sum_ovf), 0);
        rst_n = 1'b1;
        for (int pol = 0; pol < 4; pol++)
            for (int v = 0; v < 16; v++)
                for (int a = 0; a < 16; a++)
                    for (int k = 0; k < 4; k++)
                        run_vec(pol, v, a, k);
        // R2: one idle cycle after traffic leaves the outputs quiet
        req_valid = '0;
        @(negedge clk);
        chk("R2", "commit_en idle", int'(commit_en), 0);
        chk("R2", "fail idle", int'(fail), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule